// File: doc/BRIEF.md
# Key-Unlocked Configuration Port with Watchdog

This block puts a watchdog timer behind a legacy index/data byte-port pair. A host reaches it with single-byte reads and writes on a small address bus. A strap input picks where the port pair sits. The space is locked after reset. To open it, the host writes a two-byte key to the index port. Once open, the host writes an index to the index port and then reads or writes the selected register through the data port. The data port always sits at the index address plus one.

Registers are banked by a logical-device number. The chip identifier is visible in every bank. The watchdog lives in bank 8. Writing a non-zero byte to its timeout register loads the countdown and starts it. Rewriting that register is the keep-alive. Writing zero stops the countdown.

The counter steps down once per time-base tick, and the tick period is a parameter. When the counter reaches zero, the block drives a reset pulse of parameterised length and sets a sticky timeout flag. An armed watchdog keeps running after the host locks the space again.

Top module: `cfgport_wdog`

## Requirements
- R1: After reset the space is locked, the logical device and index are 0, the watchdog is stopped, `bus_rdata` is 0xFF, and `wdt_rst` and `timeout_flag` are low.
- R2: The space unlocks only after 0x87 is written to the index port on two consecutive index-port writes. While locked, every read returns 0xFF. While unlocked, a read of the index port returns the last index written.
- R3: An index-port write of any byte other than 0x87 after a single 0x87 cancels the partial key, so the sequence 0x87, 0x12, 0x87 leaves the space locked.
- R4: While unlocked, writing 0xAA to the index port locks the space, and the byte is not stored as an index.
- R5: With `base_sel` = 0 the index port is at 0x2E and the data port at 0x2F. With `base_sel` = 1 they are at 0x4E and 0x4F. Reads of any other address return 0xFF, and writes to any other address have no effect.
- R6: Index 0x07 is the logical-device register. A data-port write to it sets the active device, and a data-port read returns that device.
- R7: Index 0x20 reads 0xB0 through the data port, whatever logical device is active.
- R8: Index 0xF6 of logical device 8 reads the current counter value. In any other device, index 0xF6 and every other unimplemented index read 0xFF and ignore writes.
- R9: A non-zero write to 0xF6 of device 8 loads the counter and restarts the tick phase. The counter then drops by one every TICK_CYCLES clocks. Rewriting the register before it expires prevents the timeout, and the countdown continues after the space is locked.
- R10: Writing 0 to 0xF6 of device 8 stops the countdown, and no timeout follows.
- R11: When the counter steps from 1 to 0, `wdt_rst` is high for exactly RST_CYCLES clocks, starting the cycle after that step. The counter then stays at 0.
- R12: `timeout_flag` rises together with `wdt_rst` and stays high until the synchronous reset.
- R13: Data-port writes made while the space is locked change no register.
- R14: `bus_rdata` shows the value read in the cycle after `bus_rd` is high, and shows 0xFF in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Strap: 0 puts the port pair at 0x2E/0x2F, 1 puts it at 0x4E/0x4F |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wdt_rst | output | 1 | Watchdog reset pulse |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
If the unlock state is wrong, it shows at the very next read. A port that should be open reads 0xFF, or a locked port returns register contents. If the index or device registers are wrong, the next data-port read returns the wrong byte.

Errors in the countdown show up more slowly. A bad prescaler or counter value shows at the next read of the timeout register. Otherwise it shows as a reset pulse that comes a whole tick early or late, or that is the wrong width. The bench compares the ports against a behavioural model on every clock, so the first wrong cycle is reported.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] REG_DEVSEL = 8'h07;
  localparam logic [7:0] REG_IDENT  = 8'h20;
  localparam logic [7:0] REG_WDTIME = 8'hF6;
  localparam logic [7:0] DEV_WDOG   = 8'h08;
  localparam logic [7:0] IDENT_VAL  = 8'hB0;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam logic [15:0] BASE_LO   = 16'h002E;
  localparam logic [15:0] BASE_HI   = 16'h004E;
endpackage

// File: rtl/cfg_keylock.sv
module cfg_keylock
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_q
);
  logic half_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      half_key <= 1'b0;
    end else if (idx_wr) begin
      if (open_q) begin
        if (wdata == KEY_CLOSE) open_q <= 1'b0;
        half_key <= 1'b0;
      end else if (wdata == KEY_OPEN) begin
        if (half_key) begin
          open_q   <= 1'b1;
          half_key <= 1'b0;
        end else begin
          half_key <= 1'b1;
        end
      end else begin
        half_key <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TICK_CYCLES = 33_000_000,
  parameter int RST_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] count,
  output logic       pulse,
  output logic       expired
);
  localparam int PW  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int CW  = $clog2(RST_CYCLES + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LEN = CW'(RST_CYCLES);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      pre_q   <= '0;
      left_q  <= '0;
      expired <= 1'b0;
    end else begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      if (load) begin
        count <= load_val;
        pre_q <= '0;
      end else if (count != 8'd0) begin
        if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          count <= count - 8'd1;
          if (count == 8'd1) begin
            left_q  <= PULSE_LEN;
            expired <= 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/cfgport_wdog.sv
module cfgport_wdog
  import cfgport_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int TICK_CYCLES = 33_000_000,
  parameter int RST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_rst,
  output logic              timeout_flag
);
  localparam logic [ADDR_W-1:0] IDX_LO = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] IDX_HI = ADDR_W'(BASE_HI);

  logic [ADDR_W-1:0] idx_addr;
  logic              hit_idx, hit_dat, unlocked;
  logic [7:0]        index_q, ldn_q, rd_val, wd_count;
  logic              wd_load;

  assign idx_addr = base_sel ? IDX_HI : IDX_LO;
  assign hit_idx  = (bus_addr == idx_addr);
  assign hit_dat  = (bus_addr == idx_addr + 1'b1);

  cfg_keylock u_key (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (bus_wr & hit_idx),
    .wdata  (bus_wdata),
    .open_q (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else if (bus_wr && unlocked) begin
      if (hit_idx && bus_wdata != KEY_CLOSE) index_q <= bus_wdata;
      if (hit_dat && index_q == REG_DEVSEL) ldn_q <= bus_wdata;
    end
  end

  assign wd_load = bus_wr && unlocked && hit_dat &&
                   index_q == REG_WDTIME && ldn_q == DEV_WDOG;

  wdog_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .RST_CYCLES  (RST_CYCLES)
  ) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .load     (wd_load),
    .load_val (bus_wdata),
    .count    (wd_count),
    .pulse    (wdt_rst),
    .expired  (timeout_flag)
  );

  always_comb begin
    rd_val = IDLE_BYTE;
    if (unlocked) begin
      if (hit_idx) begin
        rd_val = index_q;
      end else if (hit_dat) begin
        unique case (index_q)
          REG_DEVSEL: rd_val = ldn_q;
          REG_IDENT:  rd_val = IDENT_VAL;
          REG_WDTIME: rd_val = (ldn_q == DEV_WDOG) ? wd_count : IDLE_BYTE;
          default:    rd_val = IDLE_BYTE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= IDLE_BYTE;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= IDLE_BYTE;
  end
endmodule

// File: rtl/cfgport_wdog_chk.sv
module cfgport_wdog_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_rd,
  input logic [7:0] rdata,
  input logic       wdt_rst,
  input logic       flag,
  input logic       unlocked,
  input logic       wd_load,
  input logic [7:0] wd_count
);
  int hi_run;

  always_ff @(posedge clk) begin
    if (rst)          hi_run <= 0;
    else if (wdt_rst) hi_run <= hi_run + 1;
    else              hi_run <= 0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (rdata == 8'hFF && !wdt_rst && !flag));

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && bus_rd) |=> rdata == 8'hFF);

  // R14
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> rdata == 8'hFF);

  // R9
  count_down_only_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_load |=> wd_count <= $past(wd_count));

  // R11
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst) |-> hi_run == RST_CYCLES);

  // R11
  pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
    hi_run <= RST_CYCLES);

  // R12
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> flag);

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);
endmodule

bind cfgport_wdog cfgport_wdog_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .rdata    (bus_rdata),
  .wdt_rst  (wdt_rst),
  .flag     (timeout_flag),
  .unlocked (unlocked),
  .wd_load  (wd_load),
  .wd_count (wd_count)
);

// File: tb/cfgport_wdog_test.sv
module cfgport_wdog_test;
  localparam int TICK = 5;
  localparam int RSTC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_sel = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        wdt_rst, timeout_flag;

  always #5 clk = ~clk;

  cfgport_wdog #(.ADDR_W(16), .TICK_CYCLES(TICK), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst(rst), .base_sel(base_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst(wdt_rst), .timeout_flag(timeout_flag)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;

  // behavioural reference model
  int m_unl, m_arm, m_idx, m_ldn, m_cnt, m_pre, m_pul, m_flag, m_rd;

  always @(posedge clk) begin
    int rv, ib;
    bit hi, hd;
    started = 1;
    cycles++;
    ib = base_sel ? 'h4E : 'h2E;
    hi = (bus_addr == ib);
    hd = (bus_addr == ib + 1);
    if (rst) begin
      m_unl = 0; m_arm = 0; m_idx = 0; m_ldn = 0;
      m_cnt = 0; m_pre = 0; m_pul = 0; m_flag = 0; m_rd = 255;
    end else begin
      rv = 255;
      if (bus_rd && m_unl != 0) begin
        if (hi) rv = m_idx;
        else if (hd) begin
          if (m_idx == 7) rv = m_ldn;
          else if (m_idx == 'h20) rv = 'hB0;
          else if (m_idx == 'hF6 && m_ldn == 8) rv = m_cnt;
        end
      end
      m_rd = bus_rd ? rv : 255;
      if (m_pul > 0) m_pul--;
      if (bus_wr && m_unl != 0 && hd && m_idx == 'hF6 && m_ldn == 8) begin
        m_cnt = bus_wdata; m_pre = 0;
      end else if (m_cnt > 0) begin
        m_pre++;
        if (m_pre == TICK) begin
          m_pre = 0; m_cnt--;
          if (m_cnt == 0) begin m_pul = RSTC; m_flag = 1; end
        end
      end
      if (bus_wr && hd && m_unl != 0 && m_idx == 7) m_ldn = bus_wdata;
      if (bus_wr && hi) begin
        if (m_unl != 0) begin
          if (bus_wdata == 8'hAA) m_unl = 0; else m_idx = bus_wdata;
        end else if (bus_wdata == 8'h87) begin
          if (m_arm != 0) begin m_unl = 1; m_arm = 0; end else m_arm = 1;
        end else m_arm = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (bus_rdata !== m_rd[7:0]) begin
        errors++;
        $display("FAIL R14 model rdata actual %h expected %h", bus_rdata, m_rd[7:0]);
      end
      if (wdt_rst !== (m_pul > 0)) begin
        errors++;
        $display("FAIL R11 model wdt_rst actual %b expected %b", wdt_rst, (m_pul > 0));
      end
      if (timeout_flag !== (m_flag != 0)) begin
        errors++;
        $display("FAIL R12 model flag actual %b expected %b", timeout_flag, (m_flag != 0));
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic wait_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, {7'b0, wdt_rst}, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'hFF);
    chk("R1 wdt_rst", {7'b0, wdt_rst}, 8'h00);
    chk("R1 flag", {7'b0, timeout_flag}, 8'h00);
    // R2 locked reads
    rd(16'h2E, 8'hFF, "R2 locked index");
    rd(16'h2F, 8'hFF, "R2 locked data");
    // R3 broken key
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h12); wr(16'h2E, 8'h87);
    rd(16'h2E, 8'hFF, "R3 broken key stays locked");
    wr(16'h2E, 8'h87);
    wr(16'h2E, 8'h20);
    rd(16'h2E, 8'h20, "R2 unlocked index readback");
    rd(16'h2F, 8'hB0, "R7 chip id");
    // R13 and R4: locked data write ignored
    wr(16'h2E, 8'h07);
    wr(16'h2E, 8'hAA);
    rd(16'h2F, 8'hFF, "R4 locked after exit key");
    wr(16'h2F, 8'h08);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    rd(16'h2E, 8'h07, "R4 exit key not stored as index");
    rd(16'h2F, 8'h00, "R13 locked write ignored");
    // R6 device select
    wr(16'h2F, 8'h08);
    rd(16'h2F, 8'h08, "R6 device readback");
    rd(16'h2E, 8'h07, "R6 index kept");
    // R5 undecoded
    rd(16'h0030, 8'hFF, "R5 undecoded read");
    wr(16'h4E, 8'hAA);
    rd(16'h2E, 8'h07, "R5 other strap address ignored");
    // R7 id under device 8
    wr(16'h2E, 8'h20);
    rd(16'h2F, 8'hB0, "R7 id in device 8");
    // R8 counter idle
    wr(16'h2E, 8'hF6);
    rd(16'h2F, 8'h00, "R8 idle counter");
    // R9/R11 expiry timing, value 2
    wr(16'h2F, 8'h02);
    repeat (9) @(negedge clk);
    chk("R11 no pulse before expiry", {7'b0, wdt_rst}, 8'h00);
    @(negedge clk);
    chk("R11 pulse at expiry", {7'b0, wdt_rst}, 8'h01);
    chk("R12 flag at expiry", {7'b0, timeout_flag}, 8'h01);
    begin
      int hi_n = 1;
      for (int i = 0; i < 10 && wdt_rst; i++) begin
        @(negedge clk);
        if (wdt_rst) hi_n++;
      end
      chk("R11 pulse width", 8'(hi_n), 8'(RSTC));
    end
    wait_quiet(20, "R11 no repeat after expiry");
    rd(16'h2F, 8'h00, "R11 counter stays zero");
    // R9 pace of decrement
    wr(16'h2F, 8'h04);
    repeat (4) @(negedge clk);
    rd(16'h2F, 8'h04, "R9 before first tick");
    rd(16'h2F, 8'h03, "R9 after first tick");
    // R9 keep-alive
    for (int k = 0; k < 6; k++) begin
      wr(16'h2F, 8'h03);
      wait_quiet(10, "R9 keep-alive");
    end
    // R9 keeps running after lock
    wr(16'h2E, 8'hAA);
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (wdt_rst) seen = 1;
      end
      chk("R9 expiry while locked", {7'b0, seen}, 8'h01);
    end
    // R10 zero disables
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    wr(16'h2F, 8'h05);
    wr(16'h2F, 8'h00);
    wait_quiet(50, "R10 disabled");
    rd(16'h2F, 8'h00, "R10 counter zero");
    // R8 other device
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h03);
    wr(16'h2E, 8'hF6); wr(16'h2F, 8'h02);
    rd(16'h2F, 8'hFF, "R8 other device reads FF");
    wait_quiet(30, "R8 other device write ignored");
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h08); wr(16'h2E, 8'hF6);
    rd(16'h2F, 8'h00, "R8 device 8 counter untouched");
    // R12 sticky until reset
    chk("R12 flag still set", {7'b0, timeout_flag}, 8'h01);
    rst = 1'b1; base_sel = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 flag cleared by reset", {7'b0, timeout_flag}, 8'h00);
    // R5 alternate strap
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
    wr(16'h4E, 8'h20);
    rd(16'h4F, 8'hB0, "R5 alternate data port");
    rd(16'h2F, 8'hFF, "R5 old data port undecoded");
    rd(16'h4E, 8'h20, "R5 alternate index port");
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL all requirements: run hung, actual %0d cycles expected completion", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule